// File: doc/BRIEF.md
# Non-Redundant Radix-4 Signed-Digit Recoder

This block turns an N-bit two's-complement word (N even, K = N/2) into K radix-4 digits. A parameter selects one of two recoding variants. Each low digit is built by rippling a carry through two half adders. One is a normal half adder. The other is a sign-inverted half adder, whose carry and sum obey 2·carry − sum = in1 + in2. In the negative-leaning variant the sign-inverted half adder sits on the odd bit, so its sum has weight −2. In the positive-leaning variant it sits on the even bit, so its sum has weight −1. The two pair bits that define each low digit are the form a coefficient store would hold. The most significant digit is formed by ordinary radix-4 Booth recoding of the top two input bits and the incoming carry.

For every digit the block outputs the two pair bits and four select lines (+1, −1, +2, −2) that a partial-product generator would consume. A parameter chooses whether the outputs come straight from the logic or from a register stage that clears on reset.

Top module: `nr4sd_recoder`

## Requirements
- R1: For every N-bit input x, the sum over j of digit_j · 4^j equals x read as two's complement, including the most negative and the most positive values.
- R2: With PLUS_FORM = 0, every digit except the top one lies in {−2, −1, 0, 1}, so its +2 select is never high.
- R3: With PLUS_FORM = 1, every digit except the top one lies in {−1, 0, 1, 2}, so its −2 select is never high.
- R4: The top digit equals −2·din[N−1] + din[N−2] + top_carry and lies in {−2..2}. top_carry is the ripple carry into the top digit.
- R5: For each digit, at most one of sel_p1, sel_m1, sel_p2 and sel_m2 is high. When none is high the digit is zero.
- R6: For a low digit, pair_hi and pair_lo give its value. With PLUS_FORM = 0 the value is pair_lo − 2·pair_hi. With PLUS_FORM = 1 it is 2·pair_hi − pair_lo. For the top digit, pair_hi and pair_lo are din[N−1] and din[N−2].
- R7: The carry into digit 0 is zero. Digit 0 is therefore din[0] − 2·din[1] with PLUS_FORM = 0, and 2·(din[1] XOR din[0]) − din[0] with PLUS_FORM = 1.
- R8: With REG_OUT = 1, every output reflects the input sampled at the previous rising clock edge, and all outputs are zero while rst_n is low. With REG_OUT = 0, the outputs follow din in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset that clears the output register |
| din | input | N | Two's-complement word to recode |
| sel_p1 | output | K | Per-digit select: digit is +1 |
| sel_m1 | output | K | Per-digit select: digit is −1 |
| sel_p2 | output | K | Per-digit select: digit is +2 |
| sel_m2 | output | K | Per-digit select: digit is −2 |
| pair_hi | output | K | Per-digit upper pair bit (odd-position sum, or din[N−1] for the top digit) |
| pair_lo | output | K | Per-digit lower pair bit (even-position sum, or din[N−2] for the top digit) |
| top_carry | output | 1 | Ripple carry entering the top digit |

## Verification
A wrong carry anywhere in the ripple moves weight between neighbouring digits. It shows up at once as a digit sum that no longer equals the input, in the same cycle for the direct variant and one cycle later for the registered one. A swapped half-adder role breaks the allowed digit range or the agreement between pair bits and select lines, and values with long runs of ones expose it. Every 8-bit value is driven through both variants so that each carry pattern, including the extremes, reaches the ports.

// File: rtl/nr4sd_recoder.sv
module nr4sd_recoder #(
  parameter int N         = 8,
  parameter int PLUS_FORM = 0,
  parameter int REG_OUT   = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N/2-1:0] sel_p1,
  output logic [N/2-1:0] sel_m1,
  output logic [N/2-1:0] sel_p2,
  output logic [N/2-1:0] sel_m2,
  output logic [N/2-1:0] pair_hi,
  output logic [N/2-1:0] pair_lo,
  output logic           top_carry
);
  localparam int K = N / 2;

  logic [K-1:0] cy;
  logic [K-1:0] hi_c, lo_c, p1_c, m1_c, p2_c, m2_c;

  assign cy[0] = 1'b0;

  function automatic logic signed [N+1:0] value_of(
    input logic [K-1:0] a, input logic [K-1:0] b,
    input logic [K-1:0] c, input logic [K-1:0] d);
    logic signed [N+1:0] acc, dig;
    acc = '0;
    for (int i = 0; i < K; i++) begin
      dig = a[i] ? (N+2)'(1) : b[i] ? -(N+2)'(1) : c[i] ? (N+2)'(2) : d[i] ? -(N+2)'(2) : '0;
      acc = acc + (dig <<< (2 * i));
    end
    return acc;
  endfunction

  for (genvar j = 0; j < K; j++) begin : g_dig
    if (j < K - 1) begin : g_low
      logic mid;
      assign lo_c[j] = din[2*j] ^ cy[j];
      if (PLUS_FORM == 0) begin : g_minus
        assign mid       = din[2*j] & cy[j];
        assign hi_c[j]   = din[2*j+1] ^ mid;
        assign cy[j+1]   = din[2*j+1] | mid;
        assign p1_c[j]   = lo_c[j] & ~hi_c[j];
        assign m1_c[j]   = lo_c[j] & hi_c[j];
        assign p2_c[j]   = 1'b0;
        assign m2_c[j]   = ~lo_c[j] & hi_c[j];
      end else begin : g_plus
        assign mid       = din[2*j] | cy[j];
        assign hi_c[j]   = din[2*j+1] ^ mid;
        assign cy[j+1]   = din[2*j+1] & mid;
        assign p1_c[j]   = hi_c[j] & lo_c[j];
        assign m1_c[j]   = ~hi_c[j] & lo_c[j];
        assign p2_c[j]   = hi_c[j] & ~lo_c[j];
        assign m2_c[j]   = 1'b0;
      end
    end else begin : g_top
      logic h, l, c;
      assign h = din[N-1];
      assign l = din[N-2];
      assign c = cy[j];
      assign hi_c[j] = h;
      assign lo_c[j] = l;
      assign p1_c[j] = ~h & (l ^ c);
      assign m1_c[j] = h & (l ^ c);
      assign p2_c[j] = ~h & l & c;
      assign m2_c[j] = h & ~l & ~c;
    end
  end

  if (REG_OUT != 0) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_p1 <= '0; sel_m1 <= '0; sel_p2 <= '0; sel_m2 <= '0;
        pair_hi <= '0; pair_lo <= '0; top_carry <= 1'b0;
      end else begin
        sel_p1 <= p1_c; sel_m1 <= m1_c; sel_p2 <= p2_c; sel_m2 <= m2_c;
        pair_hi <= hi_c; pair_lo <= lo_c; top_carry <= cy[K-1];
      end
    end
  end else begin : g_comb
    assign sel_p1 = p1_c;
    assign sel_m1 = m1_c;
    assign sel_p2 = p2_c;
    assign sel_m2 = m2_c;
    assign pair_hi = hi_c;
    assign pair_lo = lo_c;
    assign top_carry = cy[K-1];
  end

  AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    value_of(p1_c, m1_c, p2_c, m2_c) == (N+2)'($signed(din))); // R1

  for (genvar j = 0; j < K; j++) begin : g_chk
    logic signed [3:0] d_sel, d_pair;
    assign d_sel = sel_p1[j] ? 4'sd1 : sel_m1[j] ? -4'sd1 :
                   sel_p2[j] ? 4'sd2 : sel_m2[j] ? -4'sd2 : 4'sd0;
    if (j == K - 1) begin : g_t
      assign d_pair = $signed({3'b0, pair_lo[j]}) + $signed({3'b0, top_carry})
                      - $signed({2'b0, pair_hi[j], 1'b0});
    end else if (PLUS_FORM == 0) begin : g_m
      assign d_pair = $signed({3'b0, pair_lo[j]}) - $signed({2'b0, pair_hi[j], 1'b0});
    end else begin : g_p
      assign d_pair = $signed({2'b0, pair_hi[j], 1'b0}) - $signed({3'b0, pair_lo[j]});
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_p1[j], sel_m1[j], sel_p2[j], sel_m2[j]})); // R5
    AST_PAIR_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      d_sel == d_pair); // R6
    if (j < K - 1) begin : g_rng
      if (PLUS_FORM == 0) begin : g_rm
        AST_MINUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
          !sel_p2[j]); // R2
      end else begin : g_rp
        AST_PLUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
          !sel_m2[j]); // R3
      end
    end
  end
endmodule

// File: tb/tb_nr4sd_recoder.sv
module tb_nr4sd_recoder;
  localparam int N = 8;
  localparam int K = N / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] din = '0;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  logic [K-1:0] mp1, mm1, mp2, mm2, mhi, mlo; logic mtc;
  logic [K-1:0] pp1, pm1, pp2, pm2, phi, plo; logic ptc;
  logic [K-1:0] cp1, cm1, cp2, cm2, chi, clo; logic ctc;

  nr4sd_recoder #(.N(N), .PLUS_FORM(0), .REG_OUT(1)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .sel_p1(mp1), .sel_m1(mm1), .sel_p2(mp2),
    .sel_m2(mm2), .pair_hi(mhi), .pair_lo(mlo), .top_carry(mtc));
  nr4sd_recoder #(.N(N), .PLUS_FORM(1), .REG_OUT(1)) dut_p (
    .clk(clk), .rst_n(rst_n), .din(din), .sel_p1(pp1), .sel_m1(pm1), .sel_p2(pp2),
    .sel_m2(pm2), .pair_hi(phi), .pair_lo(plo), .top_carry(ptc));
  nr4sd_recoder #(.N(N), .PLUS_FORM(0), .REG_OUT(0)) dut_c (
    .clk(clk), .rst_n(rst_n), .din(din), .sel_p1(cp1), .sel_m1(cm1), .sel_p2(cp2),
    .sel_m2(cm2), .pair_hi(chi), .pair_lo(clo), .top_carry(ctc));

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dig(input logic a, input logic b, input logic c, input logic d);
    return a ? 1 : b ? -1 : c ? 2 : d ? -2 : 0;
  endfunction

  function automatic int total(input logic [K-1:0] a, input logic [K-1:0] b,
                               input logic [K-1:0] c, input logic [K-1:0] d);
    int s = 0;
    for (int i = 0; i < K; i++) s += dig(a[i], b[i], c[i], d[i]) * (4 ** i);
    return s;
  endfunction

  task automatic check_form(input int plus, input logic [N-1:0] v,
      input logic [K-1:0] a, input logic [K-1:0] b, input logic [K-1:0] c,
      input logic [K-1:0] d, input logic [K-1:0] hi, input logic [K-1:0] lo, input logic tc);
    int bad_rng = 0, bad_oh = 0, bad_pair = 0, dj, pd;
    chk(plus ? "R1 plus sum" : "R1 minus sum", total(a, b, c, d), int'($signed(v)));
    for (int i = 0; i < K; i++) begin
      dj = dig(a[i], b[i], c[i], d[i]);
      if ($countones({a[i], b[i], c[i], d[i]}) > 1) bad_oh++;
      if (i < K - 1) begin
        if (plus == 0 && (dj < -2 || dj > 1)) bad_rng++;
        if (plus == 1 && (dj < -1 || dj > 2)) bad_rng++;
        pd = plus ? 2 * int'(hi[i]) - int'(lo[i]) : int'(lo[i]) - 2 * int'(hi[i]);
        if (pd != dj) bad_pair++;
      end
    end
    chk("R5 select one-hot", bad_oh, 0);
    if (plus) chk("R3 plus digit range", bad_rng, 0);
    else chk("R2 minus digit range", bad_rng, 0);
    chk("R6 pair bits", bad_pair, 0);
    chk("R6 top pair", {hi[K-1], lo[K-1]}, int'(v[N-1:N-2]));
    chk("R4 top digit", dig(a[K-1], b[K-1], c[K-1], d[K-1]),
        int'(v[N-2]) + int'(tc) - 2 * int'(v[N-1]));
    chk("R7 digit zero", dig(a[0], b[0], c[0], d[0]),
        plus ? 2 * int'(v[1] ^ v[0]) - int'(v[0]) : int'(v[0]) - 2 * int'(v[1]));
  endtask

  logic [N-1:0] prev;
  logic have_prev = 1'b0;

  task automatic apply(input logic [N-1:0] v);
    @(negedge clk);
    din = v;
    #1;
    chk("R8 comb same-cycle", total(cp1, cm1, cp2, cm2), int'($signed(v)));
    if (have_prev) chk("R8 reg holds old", total(mp1, mm1, mp2, mm2), int'($signed(prev)));
    @(posedge clk);
    #1;
    check_form(0, v, mp1, mm1, mp2, mm2, mhi, mlo, mtc);
    check_form(1, v, pp1, pm1, pp2, pm2, phi, plo, ptc);
    prev = v;
    have_prev = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    din = 8'hA5;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset zero", int'({mp1, mm1, mp2, mm2, mhi, mlo, mtc}), 0);
    chk("R8 reset zero plus", int'({pp1, pm1, pp2, pm2, phi, plo, ptc}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(8'h80);
    apply(8'h7F);
    apply(8'hFF);
    apply(8'h00);
    apply(8'h55);
    apply(8'hAA);
    for (int v = 0; v < 256; v++) apply(N'(v));
    for (int r = 0; r < 200; r++) apply(N'($urandom));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule